// File: doc/BRIEF.md
# Tagged-Message Pixel Test Stage

This stage sits in a pixel pipeline in which everything travels as a message: a 9-bit tag that names the message type and a 32-bit data word. A message comes in through a two-entry input FIFO and leaves through a two-entry output FIFO, so the stage is decoupled from the stage before it and the stage after it. Register writes, commands, sync markers and per-pixel steps all share this single stream and keep their order.

Pixel steps carry the pixel coordinates. When a step is active, the stage tests it against a scissor rectangle and against a 32x32 stipple pattern. Each test can be enabled on its own. A step that fails an enabled test leaves the stage as a passive step and is never dropped. Later incremental units therefore still advance once for every step. Four kinds of message load the stage's own control state and are absorbed: the enables, the horizontal bounds, the vertical bounds and one stipple row. The stage forwards every other tag with no change.

Both sides use valid/ready. A word moves on a clock edge where valid and ready are both high. While valid is high and ready is low, the sender must hold valid and keep the word stable. The stage takes a message from its input FIFO only on a cycle when its output FIFO has room. A register message waits for that room as well, even though it produces no output.

Top module: `pxt_stage`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Both tests are disabled, the scissor bounds are 0 and every stipple bit is 0.
- R2: A message whose tag is not 9'h010, 9'h011, 9'h020, 9'h021, 9'h022 or 9'h040..9'h05F is forwarded with its tag and data unchanged. A sync marker is one such message.
- R3: Register messages are absorbed and are not forwarded. They act on every later message. Tag 9'h020 sets the scissor enable from data bit 0 and the stipple enable from data bit 1. Tag 9'h021 loads Xmin from data[15:0] and Xmax from data[31:16]. Tag 9'h022 loads Ymin and Ymax with the same layout.
- R4: An active step has tag 9'h010 and a passive step has tag 9'h011. The step data holds X in bits 15:0 and Y in bits 31:16, both unsigned. Step data is always forwarded unchanged.
- R5: A step that arrives passive leaves passive and is not retested.
- R6: When the scissor test is enabled, an active step passes only if Xmin <= X < Xmax and Ymin <= Y < Ymax. A failing step leaves with tag 9'h011. With both tests disabled, every active step leaves active.
- R7: Tag 9'h040+r writes the 32-bit stipple row r, where r is in 0..31. When the stipple test is enabled, an active step passes only if bit X[4:0] of row Y[4:0] is 1. Otherwise it leaves passive.
- R8: When both tests are enabled, failing either one makes the step passive.
- R9: Output order equals input order, with no loss and no duplication. While out_ready is low, out_valid and out_data hold. After four messages have been accepted with the output stalled, in_ready is 0.
- R10: A message accepted at clock edge N appears on out_valid after edge N+1. With no back-pressure, the stage accepts one message per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Input FIFO has room |
| in_tag | input | 9 | Input message tag |
| in_data | input | 32 | Input message data |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Downstream accepts output |
| out_tag | output | 9 | Output message tag |
| out_data | output | 32 | Output message data |

## Verification
Every accepted message takes exactly two register stages before it can appear at the output: it enters the input FIFO at one edge and reaches the output FIFO at the next. A directed check therefore expects out_valid low one cycle after acceptance and high one cycle later. The input ready flag depends only on registered occupancy. The bench drives and samples at the falling edge and decides at that point whether a transfer will happen at the next rising edge. It updates its reference register model in input order at that moment. Because processing is strictly in order, each output is compared against the next entry in an expected queue, whatever stall pattern the random out_ready produces.

// File: rtl/pxt_pkg.sv
package pxt_pkg;
  parameter int TAG_W    = 9;
  parameter int DATA_W   = 32;
  parameter int COORD_W  = 16;
  parameter int STIP_LOG = 5;
  parameter int FIFO_D   = 2;

  localparam int STIP_N = 1 << STIP_LOG;
  localparam int MSG_W  = TAG_W + DATA_W;

  localparam logic [TAG_W-1:0] TAG_STEP_ACT = 9'h010;
  localparam logic [TAG_W-1:0] TAG_STEP_PAS = 9'h011;
  localparam logic [TAG_W-1:0] TAG_CFG_EN   = 9'h020;
  localparam logic [TAG_W-1:0] TAG_SCIS_X   = 9'h021;
  localparam logic [TAG_W-1:0] TAG_SCIS_Y   = 9'h022;
  localparam logic [TAG_W-1:0] TAG_STIP_ROW = 9'h040;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/pxt_fifo2.sv
module pxt_fifo2 #(
  parameter int W     = 41,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign push_ready = (count != CW'(DEPTH));
  assign pop_valid  = (count != '0);
  assign pop_data   = mem[rptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: a stalled output word holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));

  // R9: occupancy never exceeds depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |=> (count <= CW'(DEPTH)));
endmodule

// File: rtl/pxt_regs.sv
module pxt_regs
  import pxt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [TAG_W-1:0]                chk_tag,
  output logic                            reg_hit,
  input  logic                            wr_en,
  input  logic [DATA_W-1:0]               wr_data,
  output logic                            scis_en,
  output logic                            stip_en,
  output logic [COORD_W-1:0]              x_min,
  output logic [COORD_W-1:0]              x_max,
  output logic [COORD_W-1:0]              y_min,
  output logic [COORD_W-1:0]              y_max,
  output logic [STIP_N-1:0][STIP_N-1:0]   stip_rows
);
  localparam int HI_W = TAG_W - STIP_LOG;

  logic is_stip;
  logic [STIP_LOG-1:0] row_sel;

  assign is_stip = (chk_tag[TAG_W-1:STIP_LOG] == TAG_STIP_ROW[TAG_W-1:STIP_LOG]);
  assign row_sel = chk_tag[STIP_LOG-1:0];
  assign reg_hit = is_stip || (chk_tag == TAG_CFG_EN) ||
                   (chk_tag == TAG_SCIS_X) || (chk_tag == TAG_SCIS_Y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scis_en <= 1'b0;
      stip_en <= 1'b0;
      x_min   <= '0;
      x_max   <= '0;
      y_min   <= '0;
      y_max   <= '0;
    end else if (wr_en) begin
      if (chk_tag == TAG_CFG_EN) begin
        scis_en <= wr_data[0];
        stip_en <= wr_data[1];
      end
      if (chk_tag == TAG_SCIS_X) begin
        x_min <= wr_data[COORD_W-1:0];
        x_max <= wr_data[2*COORD_W-1:COORD_W];
      end
      if (chk_tag == TAG_SCIS_Y) begin
        y_min <= wr_data[COORD_W-1:0];
        y_max <= wr_data[2*COORD_W-1:COORD_W];
      end
    end
  end

  for (genvar r = 0; r < STIP_N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        stip_rows[r] <= '0;
      else if (wr_en && is_stip && (row_sel == STIP_LOG'(r)))
        stip_rows[r] <= wr_data[STIP_N-1:0];
    end
  end

  // R3: an enable message takes effect on the next cycle
  p_enable_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chk_tag == TAG_CFG_EN) |=>
      (scis_en == $past(wr_data[0]) && stip_en == $past(wr_data[1])));

  // R3: enables change only through an enable message
  p_enable_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && chk_tag == TAG_CFG_EN) |=> ($stable(scis_en) && $stable(stip_en)));

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/pxt_test.sv
module pxt_test
  import pxt_pkg::*;
(
  input  logic [DATA_W-1:0]             step_data,
  input  logic                          scis_en,
  input  logic                          stip_en,
  input  logic [COORD_W-1:0]            x_min,
  input  logic [COORD_W-1:0]            x_max,
  input  logic [COORD_W-1:0]            y_min,
  input  logic [COORD_W-1:0]            y_max,
  input  logic [STIP_N-1:0][STIP_N-1:0] stip_rows,
  output logic                          pass
);
  logic [COORD_W-1:0] px, py;
  logic scis_ok, stip_ok;

  always_comb begin
    px      = step_data[COORD_W-1:0];
    py      = step_data[2*COORD_W-1:COORD_W];
    scis_ok = (px >= x_min) && (px < x_max) && (py >= y_min) && (py < y_max);
    stip_ok = stip_rows[py[STIP_LOG-1:0]][px[STIP_LOG-1:0]];
    pass    = (!scis_en || scis_ok) && (!stip_en || stip_ok);
  end
endmodule

// File: rtl/pxt_stage.sv
module pxt_stage
  import pxt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  msg_t in_msg, head, push_msg, out_msg;
  logic head_valid, head_ready;
  logic push_valid, push_ready;
  logic reg_hit, pass, head_act, head_pas, go;

  logic                          scis_en, stip_en;
  logic [COORD_W-1:0]            x_min, x_max, y_min, y_max;
  logic [STIP_N-1:0][STIP_N-1:0] stip_rows;

  assign in_msg = '{tag: in_tag, data: in_data};

  pxt_fifo2 #(.W(MSG_W), .DEPTH(FIFO_D)) u_in_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_ready(in_ready), .push_data(in_msg),
    .pop_valid(head_valid), .pop_ready(head_ready), .pop_data(head)
  );

  pxt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .chk_tag(head.tag), .reg_hit(reg_hit),
    .wr_en(go && reg_hit), .wr_data(head.data),
    .scis_en(scis_en), .stip_en(stip_en),
    .x_min(x_min), .x_max(x_max), .y_min(y_min), .y_max(y_max),
    .stip_rows(stip_rows)
  );

  pxt_test u_test (
    .step_data(head.data),
    .scis_en(scis_en), .stip_en(stip_en),
    .x_min(x_min), .x_max(x_max), .y_min(y_min), .y_max(y_max),
    .stip_rows(stip_rows), .pass(pass)
  );

  assign head_act   = (head.tag == TAG_STEP_ACT);
  assign head_pas   = (head.tag == TAG_STEP_PAS);
  assign head_ready = push_ready;
  assign go         = head_valid && head_ready;
  assign push_valid = head_valid && !reg_hit;

  always_comb begin
    push_msg = head;
    if (head_act && !pass) push_msg.tag = TAG_STEP_PAS;
  end

  pxt_fifo2 #(.W(MSG_W), .DEPTH(FIFO_D)) u_out_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_msg),
    .pop_valid(out_valid), .pop_ready(out_ready), .pop_data(out_msg)
  );

  assign out_tag  = out_msg.tag;
  assign out_data = out_msg.data;

  // R5: passive steps stay passive
  p_passive_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && head_pas) |-> (push_valid && push_msg.tag == TAG_STEP_PAS));

  // R6: no enabled test means an active step stays active
  p_disabled_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && head_act && !scis_en && !stip_en) |-> (push_msg.tag == TAG_STEP_ACT));

  // R4: step data is forwarded unchanged
  p_step_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (head_act || head_pas)) |-> (push_msg.data == head.data));

  // R2: unrecognised messages pass untouched
  p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !reg_hit && !head_act && !head_pas) |-> (push_valid && push_msg == head));
endmodule

// File: tb/sim_pxt_stage.sv
module sim_pxt_stage;
  import pxt_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [8:0]  in_tag, out_tag;
  logic [31:0] in_data, out_data;

  always #10 clk = ~clk;

  pxt_stage u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_scis, m_stip;
  int unsigned mx0, mx1, my0, my1;
  bit [31:0]   m_rows [32];
  bit [8:0]    q_tag [$];
  bit [31:0]   q_data [$];
  string       q_req [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_reg_tag(input bit [8:0] t);
    return (t == 9'h020) || (t == 9'h021) || (t == 9'h022) || (t[8:5] == 4'b0010);
  endfunction

  function automatic bit [8:0] exp_tag(input bit [8:0] t, input bit [31:0] d);
    int unsigned x, y;
    bit fail;
    if (t != 9'h010) return t;
    x = d[15:0];
    y = d[31:16];
    fail = 1'b0;
    if (m_scis && !(x >= mx0 && x < mx1 && y >= my0 && y < my1)) fail = 1'b1;
    if (m_stip && !m_rows[y[4:0]][x[4:0]]) fail = 1'b1;
    return fail ? 9'h011 : 9'h010;
  endfunction

  function automatic string req_of(input bit [8:0] t);
    if (t == 9'h011) return "R5";
    if (t == 9'h010) begin
      if (m_scis && m_stip) return "R8";
      if (m_stip) return "R7";
      return "R6";
    end
    return "R2";
  endfunction

  function automatic void model_accept(input bit [8:0] t, input bit [31:0] d);
    if (t == 9'h020) begin m_scis = d[0]; m_stip = d[1]; end
    else if (t == 9'h021) begin mx0 = d[15:0]; mx1 = d[31:16]; end
    else if (t == 9'h022) begin my0 = d[15:0]; my1 = d[31:16]; end
    else if (t[8:5] == 4'b0010) m_rows[t[4:0]] = d;
    else begin
      q_req.push_back(req_of(t));
      q_tag.push_back(exp_tag(t, d));
      q_data.push_back(d);
    end
  endfunction

  // one falling-edge step: drive, then decide transfers for the next rising edge
  task automatic tick(input int ready_pct);
    @(negedge clk);
    out_ready = ($urandom % 100) < ready_pct;
    if (out_valid && out_ready) begin
      if (q_tag.size() == 0) begin
        chk(1'b0, "R9", "unexpected output", out_tag, 0);
      end else begin
        string rq;
        bit [8:0] et;
        bit [31:0] ed;
        rq = q_req.pop_front();
        et = q_tag.pop_front();
        ed = q_data.pop_front();
        chk(out_tag == et, rq, "tag", out_tag, et);
        chk(out_data == ed, "R4", "data order", out_data, ed);
      end
    end
  endtask

  task automatic send(input bit [8:0] t, input bit [31:0] d, input int ready_pct);
    bit done;
    done = 1'b0;
    while (!done) begin
      tick(ready_pct);
      in_valid = 1'b1;
      in_tag   = t;
      in_data  = d;
      if (in_ready) begin
        model_accept(t, d);
        done = 1'b1;
      end
    end
    tick(ready_pct);
    in_valid = ($urandom % 4) == 0 ? 1'b0 : 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && q_tag.size() != 0; k++) tick(100);
    chk(q_tag.size() == 0, "R9", "all outputs delivered", q_tag.size(), 0);
  endtask

  function automatic bit [31:0] xy(input int x, input int y);
    return {y[15:0], x[15:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] dv [4];
    int acc;
    bit [31:0] held;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; in_data = '0; out_ready = 1'b0;
    m_scis = 0; m_stip = 0; mx0 = 0; mx1 = 0; my0 = 0; my1 = 0;
    for (int i = 0; i < 32; i++) m_rows[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R10 latency: accepted at edge N, visible after edge N+1
    in_valid = 1'b1; in_tag = 9'h1A5; in_data = 32'hCAFE_0001; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10", "out_valid one cycle after accept", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R10", "out_valid two cycles after accept", out_valid, 1);
    chk(out_data == 32'hCAFE_0001, "R10", "latency data", out_data, 32'hCAFE_0001);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    // R9 back-pressure: four fill the two FIFOs, then in_ready drops and output holds
    acc = 0;
    for (int k = 0; k < 20 && acc < 4; k++) begin
      dv[acc] = 32'h5500_0000 + acc;
      in_valid = 1'b1; in_tag = 9'h0F3; in_data = dv[acc];
      if (in_ready) acc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(acc == 4, "R9", "messages accepted while stalled", acc, 4);
    chk(in_ready == 1'b0, "R9", "in_ready when full", in_ready, 0);
    held = out_data;
    @(negedge clk);
    chk(out_valid && out_data == held && held == dv[0], "R9", "held output", out_data, dv[0]);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(out_valid && out_data == dv[k], "R9", "stalled order", out_data, dv[k]);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R9", "no duplicate", out_valid, 0);

    // R1: tests off after reset, zero bounds would fail any pixel
    send(9'h010, xy(5, 7), 100);
    // R3: scissor load, absorbed; R6 corners
    send(9'h021, {16'd20, 16'd10}, 100);
    send(9'h022, {16'd12, 16'd4}, 100);
    send(9'h020, 32'h1, 100);
    send(9'h010, xy(10, 4), 100);
    send(9'h010, xy(19, 11), 100);
    send(9'h010, xy(20, 5), 100);
    send(9'h010, xy(9, 5), 100);
    send(9'h010, xy(15, 12), 100);
    send(9'h010, xy(15, 3), 100);
    send(9'h011, xy(15, 6), 100);
    // R7: stipple row 3 has bit 6 only
    send(9'h043, 32'h0000_0040, 100);
    send(9'h020, 32'h2, 100);
    send(9'h010, xy(6, 3), 100);
    send(9'h010, xy(38, 35), 100);
    send(9'h010, xy(7, 3), 100);
    // R8: both
    send(9'h020, 32'h3, 100);
    send(9'h010, xy(38, 35), 100);
    send(9'h010, xy(6, 3), 100);
    send(9'h1F0, 32'h0000_0000, 100);
    drain();

    // R10 throughput: back-to-back with ready high, twenty messages in twenty cycles
    acc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      out_ready = 1'b1;
      in_valid = 1'b1; in_tag = 9'h0A0; in_data = k;
      if (in_ready) begin acc++; model_accept(9'h0A0, k); end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(acc == 20, "R10", "one message per cycle", acc, 20);
    q_tag.delete(); q_data.delete(); q_req.delete();
    repeat (4) @(negedge clk);

    // constrained random traffic
    for (int n = 0; n < 2500; n++) begin
      int r;
      bit [8:0] t;
      bit [31:0] d;
      int lo;
      r = $urandom % 100;
      if (r < 40) begin t = 9'h010; d = xy($urandom % 48, $urandom % 48); end
      else if (r < 50) begin t = 9'h011; d = xy($urandom % 48, $urandom % 48); end
      else if (r < 60) begin
        t = 9'($urandom);
        while (t == 9'h010 || t == 9'h011 || is_reg_tag(t)) t = 9'($urandom);
        d = $urandom;
      end
      else if (r < 66) begin t = 9'h020; d = $urandom; end
      else if (r < 72) begin lo = $urandom % 32; t = 9'h021; d = {16'(lo + $urandom % 33), 16'(lo)}; end
      else if (r < 78) begin lo = $urandom % 32; t = 9'h022; d = {16'(lo + $urandom % 33), 16'(lo)}; end
      else if (r < 90) begin t = 9'h040 + 9'($urandom % 32); d = $urandom; end
      else begin t = 9'h1F0; d = n; end
      send(t, d, 70);
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule